// File: doc/BRIEF.md
# Sixteen-Pin Memory-Mapped I/O Port

This block is one general-purpose I/O port of sixteen pins. Software reaches it through a small register bus: a byte address, a write-data word, a write strobe, and a read-data word that is decoded without a clock. Each pin has its own direction mode, drive type (push-pull or open-drain), a stored speed code and a pull selection. An output latch holds the level each pin drives. The block drives the pad controls for each pin: the output level, the output enable, an open-drain flag, pull-up and pull-down requests, and a flag that hands the pin to an alternate function.

Pad inputs go through a two-stage synchroniser. Software reads them back as a read-only input word. A write-only set/clear register changes single output bits in one bus write, so no read-modify-write is needed. When one write both sets and clears the same pin, the set wins.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset, every register reads zero. This includes the mode word, so every pin is an input (mode code 00). With reset held, no output enable is asserted.
- R2: Four configuration words are written and read back at their byte offsets. The mode word is at 0x00, with pin n in bits [2n+1:2n]. The drive-type word is at 0x04, with pin n in bit n (0 push-pull, 1 open-drain) and bits [31:16] reading zero. The speed word is at 0x08 and the pull word at 0x0C, each with pin n in bits [2n+1:2n]. A write takes effect on the clock edge where the write strobe is high.
- R3: The output latch is at 0x14. A write loads bits [15:0]. A read returns the latch in bits [15:0] and zero above.
- R4: The set/clear register is at 0x18. Writing 1 to bit n (n = 0..15) drives latch bit n to 1. Writing 1 to bit n+16 drives latch bit n to 0. Bits written as 0 leave the latch unchanged. The register always reads zero.
- R5: If one set/clear write has both bit n and bit n+16 at 1, latch bit n becomes 1.
- R6: The input word is at 0x10. Bits [15:0] show the pad inputs as they were two clock edges earlier. Writes to this offset change nothing.
- R7: A pin in mode 01 with push-pull drive asserts its output enable. Every pin's output level equals its latch bit.
- R8: A pin in mode 01 with open-drain drive asserts its open-drain flag. Its output enable is high only while its latch bit is 0. The block therefore never actively drives a 1 on such a pin.
- R9: Pins in mode 00 (input), 10 (alternate function) or 11 (analog) never assert output enable. The alternate-function flag is high exactly for pins in mode 10.
- R10: For each pin, pull code 01 asserts the pull-up request and code 10 asserts the pull-down request. Codes 00 and 11 assert neither.
- R11: Any other address reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, decoded combinationally |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Output level for each pin |
| pad_oe | output | 16 | Output enable for each pin |
| pad_od | output | 16 | Open-drain flag for each pin |
| pad_pu | output | 16 | Pull-up request for each pin |
| pad_pd | output | 16 | Pull-down request for each pin |
| pin_alt | output | 16 | Pin handed to its alternate function |

## Verification
A register write is sampled on the edge where the strobe is high. The new register value, and every pad control derived from it, are stable right after that edge. The bench therefore drives each write on a falling edge, lets exactly one rising edge pass, and samples read data and pad outputs on the following falling edge. Reads have no latency: the address is set on a falling edge and the data is sampled one time unit later. A pad input change needs two rising edges before it appears in the input word. The bench checks that the old value still shows after the first edge and that the new value shows after the second.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // register byte offsets
    localparam int unsigned OFF_MODE  = 32'h00;
    localparam int unsigned OFF_DRIVE = 32'h04;
    localparam int unsigned OFF_SPEED = 32'h08;
    localparam int unsigned OFF_PULL  = 32'h0C;
    localparam int unsigned OFF_INPUT = 32'h10;
    localparam int unsigned OFF_LATCH = 32'h14;
    localparam int unsigned OFF_SETCL = 32'h18;

    typedef enum logic [1:0] {
        PM_IN  = 2'b00,
        PM_OUT = 2'b01,
        PM_ALT = 2'b10,
        PM_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PL_NONE = 2'b00,
        PL_UP   = 2'b01,
        PL_DOWN = 2'b10,
        PL_RSVD = 2'b11
    } pin_pull_e;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  we,
    input  logic [NUM_PINS-1:0]   idr,
    output logic [DATA_W-1:0]     rdata,
    output logic [2*NUM_PINS-1:0] mode,
    output logic [NUM_PINS-1:0]   drive,
    output logic [2*NUM_PINS-1:0] pull,
    output logic [NUM_PINS-1:0]   latch
);
    localparam int FW = 2 * NUM_PINS;

    typedef struct packed {
        logic [FW-1:0]       mode;
        logic [FW-1:0]       speed;
        logic [FW-1:0]       pull;
        logic [NUM_PINS-1:0] drive;
        logic [NUM_PINS-1:0] latch;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                ADDR_W'(OFF_MODE):  r_d.mode  = wdata[FW-1:0];
                ADDR_W'(OFF_DRIVE): r_d.drive = wdata[NUM_PINS-1:0];
                ADDR_W'(OFF_SPEED): r_d.speed = wdata[FW-1:0];
                ADDR_W'(OFF_PULL):  r_d.pull  = wdata[FW-1:0];
                ADDR_W'(OFF_LATCH): r_d.latch = wdata[NUM_PINS-1:0];
                // clear first, then set, so set dominates
                ADDR_W'(OFF_SETCL): r_d.latch = (r_q.latch & ~wdata[NUM_PINS +: NUM_PINS])
                                              | wdata[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_MODE):  rdata = DATA_W'(r_q.mode);
            ADDR_W'(OFF_DRIVE): rdata = DATA_W'(r_q.drive);
            ADDR_W'(OFF_SPEED): rdata = DATA_W'(r_q.speed);
            ADDR_W'(OFF_PULL):  rdata = DATA_W'(r_q.pull);
            ADDR_W'(OFF_INPUT): rdata = DATA_W'(idr);
            ADDR_W'(OFF_LATCH): rdata = DATA_W'(r_q.latch);
            default:            rdata = '0;
        endcase
    end

    assign mode  = r_q.mode;
    assign drive = r_q.drive;
    assign pull  = r_q.pull;
    assign latch = r_q.latch;
endmodule

// File: rtl/pio_pad.sv
module pio_pad
    import pio_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic [2*NUM_PINS-1:0] mode,
    input  logic [NUM_PINS-1:0]   drive,
    input  logic [2*NUM_PINS-1:0] pull,
    input  logic [NUM_PINS-1:0]   latch,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   pad_pu,
    output logic [NUM_PINS-1:0]   pad_pd,
    output logic [NUM_PINS-1:0]   pin_alt
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic is_out;
        assign is_out     = (mode[2*i +: 2] == PM_OUT);
        assign pad_out[i] = latch[i];
        // open-drain pins only pull low; a 1 releases the pin
        assign pad_oe[i]  = is_out & (~drive[i] | ~latch[i]);
        assign pad_od[i]  = is_out & drive[i];
        assign pin_alt[i] = (mode[2*i +: 2] == PM_ALT);
        assign pad_pu[i]  = (pull[2*i +: 2] == PL_UP);
        assign pad_pd[i]  = (pull[2*i +: 2] == PL_DOWN);
    end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl #(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_od,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_pd,
    output logic [NUM_PINS-1:0] pin_alt
);
    localparam int SYNC_STAGES = 2;

    logic [NUM_PINS-1:0]   idr_w;
    logic [2*NUM_PINS-1:0] mode_w;
    logic [NUM_PINS-1:0]   drive_w;
    logic [2*NUM_PINS-1:0] pull_w;
    logic [NUM_PINS-1:0]   odr_w;

    pio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (idr_w)
    );

    pio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .we   (bus_we),
        .idr  (idr_w),
        .rdata(bus_rdata),
        .mode (mode_w),
        .drive(drive_w),
        .pull (pull_w),
        .latch(odr_w)
    );

    pio_pad #(.NUM_PINS(NUM_PINS)) u_pad (
        .mode   (mode_w),
        .drive  (drive_w),
        .pull   (pull_w),
        .latch  (odr_w),
        .pad_out(pad_out),
        .pad_oe (pad_oe),
        .pad_od (pad_od),
        .pad_pu (pad_pu),
        .pad_pd (pad_pd),
        .pin_alt(pin_alt)
    );
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  bus_we,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]   pad_in,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_od,
    input logic [2*NUM_PINS-1:0] mode_q,
    input logic [NUM_PINS-1:0]   odr_q
);
    logic [1:0] edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              edges_q <= 2'd0;
        else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
    end

    logic [NUM_PINS-1:0] out_pins;
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++)
            out_pins[i] = (mode_q[2*i +: 2] == PM_OUT);
    end

    logic mapped;
    always_comb begin
        mapped = (bus_addr == ADDR_W'(OFF_MODE))  || (bus_addr == ADDR_W'(OFF_DRIVE)) ||
                 (bus_addr == ADDR_W'(OFF_SPEED)) || (bus_addr == ADDR_W'(OFF_PULL))  ||
                 (bus_addr == ADDR_W'(OFF_INPUT)) || (bus_addr == ADDR_W'(OFF_LATCH)) ||
                 (bus_addr == ADDR_W'(OFF_SETCL));
    end

    // R4 and R5: set/clear write updates latch, set dominating
    p_setclr_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SETCL)) |=>
        odr_q == (($past(odr_q) & ~$past(bus_wdata[NUM_PINS +: NUM_PINS]))
                  | $past(bus_wdata[NUM_PINS-1:0])));

    p_setclr_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_SETCL)) |-> bus_rdata == '0);

    p_input_two_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == 2'd2 && bus_addr == ADDR_W'(OFF_INPUT)) |->
        bus_rdata[NUM_PINS-1:0] == $past(pad_in, 2));

    p_od_never_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_od & pad_out) == '0);

    p_oe_only_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~out_pins) == '0);

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);

    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> ($stable(odr_q) && $stable(mode_q)));
endmodule

bind pio_port_ctrl pio_port_chk #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_od   (pad_od),
    .mode_q   (mode_w),
    .odr_q    (odr_w)
);

// File: tb/sim_pio_port_ctrl.sv
module sim_pio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, pin_alt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // shadow state built from the requirements
    logic [31:0] m_mode = '0, m_speed = '0, m_pull = '0;
    logic [15:0] m_drive = '0, m_latch = '0, m_pad = '0;

    always #4 clk = ~clk;

    pio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pin_alt(pin_alt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_mode;
            5'h04:   return {16'h0, m_drive};
            5'h08:   return m_speed;
            5'h0C:   return m_pull;
            5'h10:   return {16'h0, m_pad};
            5'h14:   return {16'h0, m_latch};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++)
            if (m_mode[2*i +: 2] == 2'b01) r[i] = m_drive[i] ? ~m_latch[i] : 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_field(input logic [31:0] f, input logic [1:0] code);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) r[i] = (f[2*i +: 2] == code);
        return r;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            5'h00: m_mode  = d;
            5'h04: m_drive = d[15:0];
            5'h08: m_speed = d;
            5'h0C: m_pull  = d;
            5'h14: m_latch = d[15:0];
            5'h18: m_latch = (m_latch & ~d[31:16]) | d[15:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic pads_chk();
        chk("R7 pad_out", {16'h0, pad_out}, {16'h0, m_latch});
        chk("R7/R8 pad_oe", {16'h0, pad_oe}, {16'h0, exp_oe()});
        chk("R8 pad_od", {16'h0, pad_od}, {16'h0, exp_field(m_mode, 2'b01) & m_drive});
        chk("R9 pin_alt", {16'h0, pin_alt}, {16'h0, exp_field(m_mode, 2'b10)});
        chk("R10 pad_pu", {16'h0, pad_pu}, {16'h0, exp_field(m_pull, 2'b01)});
        chk("R10 pad_pd", {16'h0, pad_pd}, {16'h0, exp_field(m_pull, 2'b10)});
    endtask

    task automatic all_regs_chk(input string req);
        rd_chk(req, 5'h00); rd_chk(req, 5'h04); rd_chk(req, 5'h08);
        rd_chk(req, 5'h0C); rd_chk(req, 5'h10); rd_chk(req, 5'h14);
        rd_chk(req, 5'h18);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [4:0]  a;
        logic [31:0] d;
        void'($urandom(32'd7301));
        #1;
        // R1: outputs held off during reset
        chk("R1 oe in reset", {16'h0, pad_oe}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_regs_chk("R1 reset value");
        pads_chk();

        // R6: two-edge synchroniser, old value after one edge
        @(negedge clk);
        pad_in = 16'hA5C3; bus_addr = 5'h10;
        @(negedge clk); #1;
        chk("R6 one edge", bus_rdata, 32'h0);
        @(negedge clk); #1;
        chk("R6 two edges", bus_rdata, 32'h0000_A5C3);
        m_pad = 16'hA5C3;
        wr(5'h10, 32'hFFFF_0000);
        rd_chk("R6 write ignored", 5'h10);

        // R2, R3 directed
        wr(5'h00, 32'h1B1B_E4E4); rd_chk("R2 mode", 5'h00);
        wr(5'h04, 32'hFFFF_5A5A); rd_chk("R2 drive upper zero", 5'h04);
        wr(5'h08, 32'h1234_5678); rd_chk("R2 speed", 5'h08);
        wr(5'h14, 32'hDEAD_BEEF); rd_chk("R3 latch", 5'h14);

        // R5: set beats clear; expected latch 0x01C1
        wr(5'h14, 32'h0000_00F0);
        wr(5'h18, 32'h0130_0101);
        bus_addr = 5'h14; #1;
        chk("R5 set wins", bus_rdata, 32'h0000_01C1);
        rd_chk("R4 reads zero", 5'h18);

        // R7: all push-pull outputs
        wr(5'h00, 32'h5555_5555); wr(5'h04, 32'h0);
        #1; chk("R7 oe all", {16'h0, pad_oe}, 32'h0000_FFFF);
        // R8: open-drain, latch 0x00FF -> oe on upper byte only
        wr(5'h04, 32'h0000_FFFF); wr(5'h14, 32'h0000_00FF);
        #1; chk("R8 od oe", {16'h0, pad_oe}, 32'h0000_FF00);
        chk("R8 od flag", {16'h0, pad_od}, 32'h0000_FFFF);
        // R9: alternate mode
        wr(5'h00, 32'hAAAA_AAAA);
        #1; chk("R9 alt oe", {16'h0, pad_oe}, 32'h0);
        chk("R9 alt flag", {16'h0, pin_alt}, 32'h0000_FFFF);
        // R10: codes cycle none/up/down/rsvd per pin
        wr(5'h0C, 32'hE4E4_E4E4);
        #1; chk("R10 up", {16'h0, pad_pu}, 32'h0000_2222);
        chk("R10 down", {16'h0, pad_pd}, 32'h0000_4444);
        // R11: unmapped writes and reads
        wr(5'h1C, 32'hFFFF_FFFF); wr(5'h02, 32'hFFFF_FFFF);
        rd_chk("R11 read 1C", 5'h1C);
        all_regs_chk("R11 no change");

        // random mix
        for (int k = 0; k < 300; k++) begin
            int unsigned sel = $urandom % 10;
            d = $urandom;
            case (sel)
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h0C;
                4: a = 5'h10; 5: a = 5'h14; 6, 7: a = 5'h18;
                8: a = 5'h1C;
                default: a = {3'($urandom % 7), 2'b01};
            endcase
            wr(a, d);
            rd_chk("R2/R3/R4/R11 random", a);
            rd_chk("R3/R4 random latch", 5'h14);
            pads_chk();
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule